// File: doc/BRIEF.md
# SD SPI Single-Block Data Phase Engine

This block runs the data phase of one single-block SD card transfer over SPI. It starts after the read or write command has already been accepted by the card. A host controller gives it a direction and a byte count. The engine then holds chip select low for the whole exchange and drives a byte-wide SPI shifter through a request/done handshake. On the local side it moves data through a byte-stream port that uses valid/ready handshakes.

In read mode the engine sends filler bytes (0xFF) and hunts for the start token 0xFE. It then passes the requested number of data bytes to the read stream: 512 for a sector, 16 for a card register. It then clocks out the two CRC bytes and discards them. In write mode it sends the start token, the data bytes taken from the write stream, and two 0xFF bytes in place of a CRC. It then decodes the card's data response token. After an accepted write it polls while the card reports busy (0x00).

Every transfer ends the same way. Chip select goes high, one more 0xFF byte is clocked, and then a one-cycle `done` pulse is given with a 2-bit status. The token hunt and the busy wait are each bounded by `POLL_LIMIT` polls, so a silent card produces a timeout status and the engine does not hang.

States:
- `ST_IDLE`: waits for `start`.
- `ST_RD_HUNT`: exchanges 0xFF until 0xFE arrives.
- `ST_RD_XFER`: receives one data byte.
- `ST_RD_PUSH`: offers that byte on the read stream.
- `ST_RD_CRC`: discards two bytes.
- `ST_WR_TOKEN`: sends 0xFE.
- `ST_WR_FETCH`: takes one byte from the write stream.
- `ST_WR_XFER`: sends that byte.
- `ST_WR_CRC`: sends two 0xFF bytes.
- `ST_WR_RESP`: reads and decodes the response token.
- `ST_WR_BUSY`: polls while the card returns 0x00.
- `ST_CLOSE`: chip select high, one 0xFF byte.
- `ST_FIN`: `done` pulse.

Transitions:
- IDLE goes to WR_TOKEN or RD_HUNT on `start`.
- HUNT goes to RD_XFER on the token, or to CLOSE on timeout.
- RD_XFER goes to RD_PUSH.
- RD_PUSH goes to RD_XFER, or to RD_CRC after the last byte.
- RD_CRC goes to CLOSE after the second byte.
- WR_TOKEN goes to WR_FETCH.
- WR_FETCH goes to WR_XFER.
- WR_XFER goes to WR_FETCH, or to WR_CRC after the last byte.
- WR_CRC goes to WR_RESP after the second byte.
- WR_RESP goes to WR_BUSY when the token is accepted, otherwise to CLOSE.
- WR_BUSY goes to CLOSE on a nonzero byte or on timeout.
- CLOSE goes to FIN.
- FIN goes to IDLE.

Top module: `sdx_block_engine`

## Requirements
- R1: After reset the engine is idle: `cs_n`=1, `busy`=0, `done`=0 and `xfer_req`=0.
- R2: A read sends 0xFF and keeps polling until a received byte equals 0xFE. Up to `POLL_LIMIT`-1 non-token bytes before the token are tolerated.
- R3: After the token, a read delivers exactly `start_len` received bytes on `rd_data`, in order. Each byte is held stable while `rd_valid`=1 and `rd_ready`=0. Exactly two further bytes are then exchanged and not delivered.
- R4: A write sends 0xFE, then `start_len` bytes taken in order from the write stream, then two 0xFF bytes. `wr_ready` stays high until a byte is taken.
- R5: The byte after the write CRC is decoded on its low five bits. The upper three bits are ignored. 00101 is accepted. 01011 gives status 01 (CRC rejected). Any other value gives status 10 (write rejected) and goes straight to the closing byte.
- R6: After an accepted write, the engine keeps polling while the received byte is 0x00 and stops on the first nonzero byte.
- R7: `POLL_LIMIT` consecutive misses in the token hunt or in the busy wait end the transfer with status 11 (timeout) and no further polling.
- R8: Every transfer ends with exactly one exchange of 0xFF with `cs_n`=1. This is followed by a `done` pulse one cycle long, with `status` 00 on success.
- R9: `start` is ignored while `busy`=1.
- R10: While `xfer_req`=1 and `xfer_done`=0, `xfer_req` stays high and `xfer_tx` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_write | input | 1 | 1 = write, 0 = read |
| start_len | input | LEN_W | Number of data bytes (1 or more) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 2 | 00 ok, 01 CRC rejected, 10 write rejected, 11 timeout |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| cs_n | output | 1 | Card chip select, active low |
| xfer_req | output | 1 | Request one SPI byte exchange |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Exchange complete, `xfer_rx` valid |
| xfer_rx | input | 8 | Byte received |

## Verification
The bench builds the engine with `LEN_W`=5 and `POLL_LIMIT`=6. With these values a timeout is reached after only six polls.

This makes it practical to sweep every gap length before the start token, and every busy length, from zero up to and past the limit. The sweeps cover several block lengths, including a single byte, and a set of response tokens with both zero and nonzero upper bits.

Throughout, the shifter latency varies from byte to byte, and the stream handshakes are throttled in a pattern that does not line up with the byte timing.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_HUNT,
        ST_RD_XFER,
        ST_RD_PUSH,
        ST_RD_CRC,
        ST_WR_TOKEN,
        ST_WR_FETCH,
        ST_WR_XFER,
        ST_WR_CRC,
        ST_WR_RESP,
        ST_WR_BUSY,
        ST_CLOSE,
        ST_FIN
    } xfer_state_t;

    typedef enum logic [1:0] {
        STS_OK      = 2'b00,
        STS_CRC_REJ = 2'b01,
        STS_WR_REJ  = 2'b10,
        STS_TIMEOUT = 2'b11
    } xfer_status_t;

    localparam logic [7:0] BLOCK_TOKEN = 8'hFE;
    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [4:0] RESP_ACCEPT = 5'b00101;
    localparam logic [4:0] RESP_CRCBAD = 5'b01011;

endpackage

// File: rtl/sdx_poll_timer.sv
module sdx_poll_timer #(
    parameter int LIMIT = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (tick && count != TOP)
            count <= count + 1'b1;
    end

    assign last = (count == TOP);

    // R7
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TOP);

endmodule

// File: rtl/sdx_resp_decode.sv
module sdx_resp_decode
    import sdx_pkg::*;
(
    input  logic [7:0]   token,
    output xfer_status_t verdict
);
    always_comb begin
        if (token[4:0] == RESP_ACCEPT)
            verdict = STS_OK;
        else if (token[4:0] == RESP_CRCBAD)
            verdict = STS_CRC_REJ;
        else
            verdict = STS_WR_REJ;
    end
endmodule

// File: rtl/sdx_block_engine.sv
module sdx_block_engine
    import sdx_pkg::*;
#(
    parameter int LEN_W      = 10,
    parameter int POLL_LIMIT = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_write,
    input  logic [LEN_W-1:0] start_len,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic             cs_n,
    output logic             xfer_req,
    output logic [7:0]       xfer_tx,
    input  logic             xfer_done,
    input  logic [7:0]       xfer_rx
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    xfer_state_t      state, state_d;
    xfer_status_t     sts_q, sts_d;
    xfer_status_t     verdict;
    logic [LEN_W-1:0] len_q, len_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             crc_q, crc_d;
    logic [7:0]       dbuf_q, dbuf_d;
    logic             tmr_clear, tmr_tick, tmr_last;
    logic             last_byte;

    sdx_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .tick  (tmr_tick),
        .last  (tmr_last)
    );

    sdx_resp_decode u_decode (
        .token   (xfer_rx),
        .verdict (verdict)
    );

    assign last_byte = (cnt_q == len_q - ONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            sts_q  <= STS_OK;
            len_q  <= '0;
            cnt_q  <= '0;
            crc_q  <= 1'b0;
            dbuf_q <= 8'h00;
        end else begin
            state  <= state_d;
            sts_q  <= sts_d;
            len_q  <= len_d;
            cnt_q  <= cnt_d;
            crc_q  <= crc_d;
            dbuf_q <= dbuf_d;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        sts_d   = sts_q;
        len_d   = len_q;
        cnt_d   = cnt_q;
        crc_d   = crc_q;
        dbuf_d  = dbuf_q;
        unique case (state)
            ST_IDLE: if (start) begin
                len_d   = start_len;
                cnt_d   = '0;
                crc_d   = 1'b0;
                sts_d   = STS_OK;
                state_d = start_write ? ST_WR_TOKEN : ST_RD_HUNT;
            end
            ST_RD_HUNT: if (xfer_done) begin
                if (xfer_rx == BLOCK_TOKEN)
                    state_d = ST_RD_XFER;
                else if (tmr_last) begin
                    sts_d   = STS_TIMEOUT;
                    state_d = ST_CLOSE;
                end
            end
            ST_RD_XFER: if (xfer_done) begin
                dbuf_d  = xfer_rx;
                state_d = ST_RD_PUSH;
            end
            ST_RD_PUSH: if (rd_ready) begin
                cnt_d   = cnt_q + ONE;
                state_d = last_byte ? ST_RD_CRC : ST_RD_XFER;
            end
            ST_RD_CRC: if (xfer_done) begin
                crc_d = ~crc_q;
                if (crc_q) state_d = ST_CLOSE;
            end
            ST_WR_TOKEN: if (xfer_done) state_d = ST_WR_FETCH;
            ST_WR_FETCH: if (wr_valid) begin
                dbuf_d  = wr_data;
                state_d = ST_WR_XFER;
            end
            ST_WR_XFER: if (xfer_done) begin
                cnt_d   = cnt_q + ONE;
                state_d = last_byte ? ST_WR_CRC : ST_WR_FETCH;
            end
            ST_WR_CRC: if (xfer_done) begin
                crc_d = ~crc_q;
                if (crc_q) state_d = ST_WR_RESP;
            end
            ST_WR_RESP: if (xfer_done) begin
                if (verdict == STS_OK)
                    state_d = ST_WR_BUSY;
                else begin
                    sts_d   = verdict;
                    state_d = ST_CLOSE;
                end
            end
            ST_WR_BUSY: if (xfer_done) begin
                if (xfer_rx != 8'h00)
                    state_d = ST_CLOSE;
                else if (tmr_last) begin
                    sts_d   = STS_TIMEOUT;
                    state_d = ST_CLOSE;
                end
            end
            ST_CLOSE: if (xfer_done) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cs_n      = 1'b0;
        xfer_req  = 1'b0;
        xfer_tx   = FILL_BYTE;
        rd_valid  = 1'b0;
        wr_ready  = 1'b0;
        done      = 1'b0;
        tmr_clear = 1'b0;
        unique case (state)
            ST_IDLE:     begin cs_n = 1'b1; tmr_clear = 1'b1; end
            ST_RD_HUNT:  xfer_req = 1'b1;
            ST_RD_XFER:  xfer_req = 1'b1;
            ST_RD_PUSH:  rd_valid = 1'b1;
            ST_RD_CRC:   xfer_req = 1'b1;
            ST_WR_TOKEN: begin xfer_req = 1'b1; xfer_tx = BLOCK_TOKEN; end
            ST_WR_FETCH: wr_ready = 1'b1;
            ST_WR_XFER:  begin xfer_req = 1'b1; xfer_tx = dbuf_q; end
            ST_WR_CRC:   xfer_req = 1'b1;
            ST_WR_RESP:  begin xfer_req = 1'b1; tmr_clear = 1'b1; end
            ST_WR_BUSY:  xfer_req = 1'b1;
            ST_CLOSE:    begin cs_n = 1'b1; xfer_req = 1'b1; end
            ST_FIN:      begin cs_n = 1'b1; done = 1'b1; end
            default:     cs_n = 1'b1;
        endcase
    end

    assign tmr_tick = xfer_done &&
                      (((state == ST_RD_HUNT) && (xfer_rx != BLOCK_TOKEN)) ||
                       ((state == ST_WR_BUSY) && (xfer_rx == 8'h00)));
    assign busy    = (state != ST_IDLE);
    assign status  = sts_q;
    assign rd_data = dbuf_q;

    // R10
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_tx)));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R4
    wr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && !wr_valid) |=> wr_ready);

    // R8
    close_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && xfer_req && xfer_done) |=> done);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/sdx_block_engine_tb.sv
module sdx_block_engine_tb;
    localparam int LEN_W = 5;
    localparam int PL    = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             start_write = 1'b0;
    logic [LEN_W-1:0] start_len = '0;
    logic             busy, done;
    logic [1:0]       status;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic             rd_ready = 1'b0;
    logic [7:0]       wr_data = 8'h00;
    logic             wr_valid = 1'b0;
    logic             wr_ready;
    logic             cs_n, xfer_req;
    logic [7:0]       xfer_tx;
    logic             xfer_done = 1'b0;
    logic [7:0]       xfer_rx = 8'h00;

    always #5 clk = ~clk;

    sdx_block_engine #(.LEN_W(LEN_W), .POLL_LIMIT(PL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
        .start_len(start_len), .busy(busy), .done(done), .status(status),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .cs_n(cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // card scenario, set by the main thread while the engine is idle
    bit       c_write = 0;
    int       c_len = 1;
    int       c_gap = 0;
    logic [7:0] c_resp = 8'h05;
    int       c_bz = 0;

    // responder bookkeeping
    int cyc = 0;
    int cur_low = 0;
    int last_low = 0;
    int close_cnt = 0;
    int tx_err = 0;
    int rd_cnt = 0;
    int rd_err = 0;
    int widx = 0;
    bit x_active = 0;
    int x_cnt = 0;

    function automatic logic [7:0] rdat(int j, int len);
        return 8'((j * 29 + len * 5 + 1) & 255);
    endfunction

    function automatic logic [7:0] wdat(int j);
        return 8'((j * 53 + 7) & 255);
    endfunction

    function automatic logic [7:0] card_byte(int i);
        if (!c_write) begin
            if (i < c_gap) return (i % 2 == 1) ? 8'hFD : 8'hFF;
            if (i == c_gap) return 8'hFE;
            if (i <= c_gap + c_len) return rdat(i - c_gap - 1, c_len);
            return 8'hFE;
        end
        if (i <= c_len + 2) return 8'hFF;
        if (i == c_len + 3) return c_resp;
        if (i < c_len + 4 + c_bz) return 8'h00;
        return 8'h80;
    endfunction

    function automatic logic [7:0] exp_tx(int i);
        if (!c_write) return 8'hFF;
        if (i == 0) return 8'hFE;
        if (i <= c_len) return wdat(i - 1);
        return 8'hFF;
    endfunction

    // SPI shifter, card and stream partners, all acting at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (xfer_done) begin
                xfer_done = 1'b0;
            end else if (x_active) begin
                x_cnt--;
                if (x_cnt == 0) begin
                    xfer_done = 1'b1;
                    x_active  = 0;
                end
            end
            if (!x_active && !xfer_done && xfer_req) begin
                x_active = 1;
                x_cnt = 1 + (cyc % 3);
                if (cs_n) begin
                    if (xfer_tx != 8'hFF) tx_err++;
                    xfer_rx = 8'hFF;
                    last_low = cur_low;
                    cur_low = 0;
                    close_cnt++;
                end else begin
                    if (xfer_tx != exp_tx(cur_low)) tx_err++;
                    xfer_rx = card_byte(cur_low);
                    cur_low++;
                end
            end
            rd_ready = (cyc % 3 != 0);
            if (rd_valid && rd_ready) begin
                if (rd_data != rdat(rd_cnt, c_len)) rd_err++;
                rd_cnt++;
            end
            if (cyc % 4 != 1) begin
                wr_valid = 1'b1;
                wr_data  = wdat(widx);
                if (wr_ready) widx++;
            end else begin
                wr_valid = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run(input bit wr, input int len, input int gap,
                       input logic [7:0] resp, input int bz, input bit poke,
                       output int sts, output int nlow, output int ncl,
                       output int terr);
        int base_cl, base_te, waited;
        c_write = wr; c_len = len; c_gap = gap; c_resp = resp; c_bz = bz;
        rd_cnt = 0; rd_err = 0; widx = 0;
        base_cl = close_cnt; base_te = tx_err;
        @(negedge clk);
        start = 1'b1; start_write = wr; start_len = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 12) begin
                start = 1'b1; start_write = ~wr; start_len = LEN_W'(3);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(done == 1'b1, "R8", "done seen", int'(done), 1);
        sts  = int'(status);
        nlow = last_low;
        ncl  = close_cnt - base_cl;
        terr = tx_err - base_te;
        @(negedge clk);
        check(done == 1'b0, "R8", "done one cycle", int'(done), 0);
    endtask

    initial begin
        int sts, nlow, ncl, terr;
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
        check(xfer_req == 1'b0, "R1", "xfer_req in reset", int'(xfer_req), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && busy == 1'b0, "R1", "cs_n/busy idle",
              int'({cs_n, busy}), 2);
        check(done == 1'b0 && xfer_req == 1'b0, "R1", "done/req idle",
              int'({done, xfer_req}), 0);

        // reads: gap sweep 0..PL over several lengths (R2, R3, R7, R8)
        foreach (lens_r[k]) begin
            for (int g = 0; g <= PL; g++) begin
                run(1'b0, lens_r[k], g, 8'h05, 0, 1'b0, sts, nlow, ncl, terr);
                if (g < PL) begin
                    check(sts == 0, "R2", "read status", sts, 0);
                    check(nlow == g + 1 + lens_r[k] + 2, "R3", "read exchanges",
                          nlow, g + 3 + lens_r[k]);
                    check(rd_cnt == lens_r[k], "R3", "bytes delivered",
                          rd_cnt, lens_r[k]);
                    check(rd_err == 0, "R3", "read data mismatches", rd_err, 0);
                end else begin
                    check(sts == 3, "R7", "hunt timeout status", sts, 3);
                    check(nlow == PL, "R7", "hunt polls", nlow, PL);
                    check(rd_cnt == 0, "R7", "no bytes on timeout", rd_cnt, 0);
                end
                check(ncl == 1, "R8", "closing exchanges", ncl, 1);
                check(terr == 0, "R2", "filler bytes sent", terr, 0);
            end
        end

        // writes accepted: busy sweep 0..PL (R4, R5, R6, R7)
        foreach (lens_w[k]) begin
            foreach (ok_tok[t]) begin
                for (int b = 0; b <= PL; b++) begin
                    run(1'b1, lens_w[k], 0, ok_tok[t], b, 1'b0,
                        sts, nlow, ncl, terr);
                    check(terr == 0, "R4", "write bytes sent", terr, 0);
                    check(widx == lens_w[k], "R4", "bytes taken", widx, lens_w[k]);
                    check(ncl == 1, "R8", "closing exchanges", ncl, 1);
                    if (b < PL) begin
                        check(sts == 0, "R6", "write status", sts, 0);
                        check(nlow == lens_w[k] + 5 + b, "R6", "busy polls",
                              nlow, lens_w[k] + 5 + b);
                    end else begin
                        check(sts == 3, "R7", "busy timeout status", sts, 3);
                        check(nlow == lens_w[k] + 4 + PL, "R7", "busy timeout polls",
                              nlow, lens_w[k] + 4 + PL);
                    end
                end
            end
        end

        // writes rejected (R5)
        foreach (bad_tok[t]) begin
            run(1'b1, 4, 0, bad_tok[t], 3, 1'b0, sts, nlow, ncl, terr);
            check(sts == bad_sts[t], "R5", "reject status", sts, bad_sts[t]);
            check(nlow == 4 + 4, "R5", "no busy poll after reject", nlow, 8);
            check(ncl == 1, "R5", "reject closes", ncl, 1);
        end

        // start pulsed mid-transfer is ignored (R9)
        run(1'b0, 7, 2, 8'h05, 0, 1'b1, sts, nlow, ncl, terr);
        check(sts == 0 && rd_err == 0, "R9", "read unaffected", sts, 0);
        check(nlow == 2 + 1 + 7 + 2, "R9", "exchange count unaffected", nlow, 12);
        check(ncl == 1, "R9", "single close", ncl, 1);
        repeat (20) @(negedge clk);
        check(busy == 1'b0 && cs_n == 1'b1, "R9", "no second transfer",
              int'({busy, cs_n}), 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    int lens_r[4] = '{1, 2, 7, 16};
    int lens_w[3] = '{1, 4, 16};
    logic [7:0] ok_tok[2] = '{8'h05, 8'hE5};
    logic [7:0] bad_tok[5] = '{8'h0B, 8'hEB, 8'h0D, 8'h1B, 8'h00};
    int bad_sts[5] = '{1, 1, 2, 2, 2};

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule